// File: doc/BRIEF.md
# Two-Best SAD Candidate Selector

This block watches the stream of matching costs that a coarse-level full block search produces and keeps the two cheapest candidates. Each candidate is a sum of absolute differences (SAD) paired with the motion vector that produced it. Two cost engines run side by side, so up to two candidates can arrive in one clock. Both are merged into a small sorted list in that cycle. The list never holds the same vector twice.

A search starts with a clear pulse. The mode input is captured at that moment. In pair mode the block keeps a best and a second-best entry, which seed the local refinements that follow. In single mode it keeps only the minimum, as the refinement levels need. When the search ends, a done pulse freezes the list. If enough distinct vectors were seen, a one-cycle result strobe follows. The stored values are driven straight onto the outputs and stay unchanged until the next clear.

Top module: `sad_pair_select`

## Requirements
- R1: After reset or a clear, both result slots read SAD 16'hFFFF with vector (0,0), and `res_vld` is low.
- R2: In pair mode (`mode_single` low at clear), `best_*` holds the lowest SAD accepted since the clear. `second_*` holds the lowest SAD among the other vectors. Neither is ever larger than the next.
- R3: When SADs are equal, the candidate that arrived first keeps the better slot. Within one cycle, source 0 counts as arriving before source 1.
- R4: Candidates on both sources in the same cycle are both merged in that cycle. A source whose valid is low has no effect.
- R5: The two slots never hold the same vector. A candidate whose vector is already stored replaces that slot's SAD only if it is strictly smaller, and the list is then reordered.
- R6: In single mode (`mode_single` high at clear), only the minimum is kept. The second slot stays at its cleared value.
- R7: A done pulse freezes both slots. Candidates presented in the done cycle or later, up to the next clear, change nothing.
- R8: `res_vld` goes high for exactly one cycle, in the cycle after the first done following a clear. It does so only if both slots are filled (pair mode) or the best slot is filled (single mode).
- R9: Clear takes priority over done and over any candidate in the same cycle.
- R10: An accepted candidate shows on the result outputs in the cycle after it was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Start a new search; samples `mode_single` |
| done | input | 1 | End of search; freezes the results |
| mode_single | input | 1 | 1 keeps only the minimum, 0 keeps two |
| in0_vld | input | 1 | Source 0 candidate valid |
| in0_sad | input | 16 | Source 0 SAD |
| in0_mvx | input | 4 | Source 0 vector x, signed |
| in0_mvy | input | 4 | Source 0 vector y, signed |
| in1_vld | input | 1 | Source 1 candidate valid |
| in1_sad | input | 16 | Source 1 SAD |
| in1_mvx | input | 4 | Source 1 vector x, signed |
| in1_mvy | input | 4 | Source 1 vector y, signed |
| res_vld | output | 1 | One-cycle result strobe |
| best_sad | output | 16 | Lowest SAD |
| best_mvx | output | 4 | Best vector x, signed |
| best_mvy | output | 4 | Best vector y, signed |
| second_sad | output | 16 | Second-lowest SAD |
| second_mvx | output | 4 | Second vector x, signed |
| second_mvy | output | 4 | Second vector y, signed |

## Verification
The hardest cases to reach are re-arrivals of an already stored vector. The sharpest one is a repeat of the second entry whose SAD undercuts the best, which forces the two slots to swap. Another is one vector arriving on both sources in the same cycle. A normal raster full search never produces either. The stimulus therefore draws vectors from a tiny pool with small SADs, which makes repeats, ties and same-cycle collisions frequent. It also plays hand-written sequences that hit the swap directly. A behavioural sorted-list model checks every cycle.

// File: rtl/sadsel_pkg.sv
`timescale 1ns/1ps
package sadsel_pkg;

    localparam int SAD_W   = 16;
    localparam int MV_W    = 4;
    localparam int NUM_SRC = 2;

    typedef struct packed {
        logic signed [MV_W-1:0] x;
        logic signed [MV_W-1:0] y;
    } mv_t;

    typedef struct packed {
        logic             vld;
        logic [SAD_W-1:0] sad;
        mv_t              mv;
    } slot_t;

    typedef struct packed {
        slot_t first;
        slot_t second;
    } pair_t;

    function automatic slot_t slot_empty();
        slot_t s;
        s.vld  = 1'b0;
        s.sad  = '1;
        s.mv.x = '0;
        s.mv.y = '0;
        return s;
    endfunction

    // candidate takes the place of an entry: entry is empty or strictly worse
    function automatic logic slot_beats(slot_t c, slot_t e);
        return !e.vld || (c.sad < e.sad);
    endfunction

    function automatic logic slot_same_mv(slot_t c, slot_t e);
        return e.vld && (c.mv == e.mv);
    endfunction

endpackage

// File: rtl/sadsel_insert.sv
`timescale 1ns/1ps
module sadsel_insert
    import sadsel_pkg::*;
(
    input  pair_t cur,
    input  slot_t cand,
    input  logic  single,
    output pair_t nxt
);

    logic hit_first;
    logic hit_second;

    assign hit_first  = slot_same_mv(cand, cur.first);
    assign hit_second = slot_same_mv(cand, cur.second);

    always_comb begin
        nxt = cur;
        if (cand.vld) begin
            if (hit_first) begin
                if (cand.sad < cur.first.sad)
                    nxt.first.sad = cand.sad;
            end else if (hit_second) begin
                if (cand.sad < cur.first.sad) begin
                    nxt.first  = cand;
                    nxt.second = cur.first;
                end else if (cand.sad < cur.second.sad) begin
                    nxt.second.sad = cand.sad;
                end
            end else if (slot_beats(cand, cur.first)) begin
                nxt.first = cand;
                if (!single)
                    nxt.second = cur.first;
            end else if (!single && slot_beats(cand, cur.second)) begin
                nxt.second = cand;
            end
        end
    end

endmodule

// File: rtl/sadsel_store.sv
`timescale 1ns/1ps
module sadsel_store
    import sadsel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  done,
    input  logic  mode_single,
    input  slot_t cand [NUM_SRC],
    output pair_t list_q,
    output logic  res_vld_q
);

    pair_t stage [NUM_SRC+1];
    logic  mode_q;
    logic  frozen_q;
    logic  accept;
    logic  enough;

    assign stage[0] = list_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
        sadsel_insert u_ins (
            .cur    (stage[g]),
            .cand   (cand[g]),
            .single (mode_q),
            .nxt    (stage[g+1])
        );
    end

    assign accept = !clr && !frozen_q && !done;
    assign enough = mode_q ? list_q.first.vld : list_q.second.vld;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            list_q.first  <= slot_empty();
            list_q.second <= slot_empty();
            frozen_q      <= 1'b0;
            res_vld_q     <= 1'b0;
            mode_q        <= rst ? 1'b0 : mode_single;
        end else begin
            res_vld_q <= 1'b0;
            if (accept) begin
                list_q <= stage[NUM_SRC];
            end else if (done && !frozen_q) begin
                frozen_q  <= 1'b1;
                res_vld_q <= enough;
            end
        end
    end

    AST_SORTED: assert property (@(posedge clk) disable iff (rst)
        list_q.second.vld |-> (list_q.first.vld && list_q.first.sad <= list_q.second.sad)); // R2

    AST_DISTINCT_MV: assert property (@(posedge clk) disable iff (rst)
        list_q.second.vld |-> (list_q.first.mv != list_q.second.mv)); // R5

    AST_SINGLE_KEEPS_ONE: assert property (@(posedge clk) disable iff (rst)
        mode_q |-> !list_q.second.vld); // R6

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (frozen_q && !clr) |=> $stable(list_q)); // R7

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        res_vld_q |=> !res_vld_q); // R8

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!list_q.first.vld && list_q.first.sad == '1 && !res_vld_q)); // R1

endmodule

// File: rtl/sad_pair_select.sv
`timescale 1ns/1ps
module sad_pair_select
    import sadsel_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   done,
    input  logic                   mode_single,
    input  logic                   in0_vld,
    input  logic [SAD_W-1:0]       in0_sad,
    input  logic signed [MV_W-1:0] in0_mvx,
    input  logic signed [MV_W-1:0] in0_mvy,
    input  logic                   in1_vld,
    input  logic [SAD_W-1:0]       in1_sad,
    input  logic signed [MV_W-1:0] in1_mvx,
    input  logic signed [MV_W-1:0] in1_mvy,
    output logic                   res_vld,
    output logic [SAD_W-1:0]       best_sad,
    output logic signed [MV_W-1:0] best_mvx,
    output logic signed [MV_W-1:0] best_mvy,
    output logic [SAD_W-1:0]       second_sad,
    output logic signed [MV_W-1:0] second_mvx,
    output logic signed [MV_W-1:0] second_mvy
);

    slot_t cand [NUM_SRC];
    pair_t list_q;

    always_comb begin
        cand[0].vld  = in0_vld;
        cand[0].sad  = in0_sad;
        cand[0].mv.x = in0_mvx;
        cand[0].mv.y = in0_mvy;
        cand[1].vld  = in1_vld;
        cand[1].sad  = in1_sad;
        cand[1].mv.x = in1_mvx;
        cand[1].mv.y = in1_mvy;
    end

    sadsel_store u_store (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr),
        .done        (done),
        .mode_single (mode_single),
        .cand        (cand),
        .list_q      (list_q),
        .res_vld_q   (res_vld)
    );

    assign best_sad   = list_q.first.sad;
    assign best_mvx   = list_q.first.mv.x;
    assign best_mvy   = list_q.first.mv.y;
    assign second_sad = list_q.second.sad;
    assign second_mvx = list_q.second.mv.x;
    assign second_mvy = list_q.second.mv.y;

endmodule

// File: tb/sad_pair_select_test.sv
`timescale 1ns/1ps
module sad_pair_select_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic done = 1'b0;
    logic mode_single = 1'b0;
    logic in0_vld = 1'b0, in1_vld = 1'b0;
    logic [15:0] in0_sad = '0, in1_sad = '0;
    logic signed [3:0] in0_mvx = '0, in0_mvy = '0, in1_mvx = '0, in1_mvy = '0;
    logic res_vld;
    logic [15:0] best_sad, second_sad;
    logic signed [3:0] best_mvx, best_mvy, second_mvx, second_mvy;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // reference model state
    int m_sad [3];
    int m_x [3];
    int m_y [3];
    int m_n = 0;
    int m_single = 0;
    int m_frozen = 0;
    int m_pulse = 0;

    always #10 clk = ~clk;

    sad_pair_select uut (
        .clk(clk), .rst(rst), .clr(clr), .done(done), .mode_single(mode_single),
        .in0_vld(in0_vld), .in0_sad(in0_sad), .in0_mvx(in0_mvx), .in0_mvy(in0_mvy),
        .in1_vld(in1_vld), .in1_sad(in1_sad), .in1_mvx(in1_mvx), .in1_mvy(in1_mvy),
        .res_vld(res_vld), .best_sad(best_sad), .best_mvx(best_mvx), .best_mvy(best_mvy),
        .second_sad(second_sad), .second_mvx(second_mvx), .second_mvy(second_mvy)
    );

    task automatic model_add(input int s, input int x, input int y);
        int cap;
        int hit;
        cap = m_single ? 1 : 2;
        hit = -1;
        for (int i = 0; i < m_n; i++)
            if (m_x[i] == x && m_y[i] == y) hit = i;
        if (hit >= 0) begin
            if (s < m_sad[hit]) m_sad[hit] = s;
        end else begin
            m_sad[m_n] = s; m_x[m_n] = x; m_y[m_n] = y;
            m_n++;
        end
        // stable insertion sort: an equal SAD never moves ahead
        for (int i = 1; i < m_n; i++)
            for (int j = i; j > 0; j--)
                if (m_sad[j] < m_sad[j-1]) begin
                    int ts, tx, ty;
                    ts = m_sad[j]; tx = m_x[j]; ty = m_y[j];
                    m_sad[j] = m_sad[j-1]; m_x[j] = m_x[j-1]; m_y[j] = m_y[j-1];
                    m_sad[j-1] = ts; m_x[j-1] = tx; m_y[j-1] = ty;
                end
        if (m_n > cap) m_n = cap;
    endtask

    always @(posedge clk) begin
        m_pulse = 0;
        if (rst || clr) begin
            m_n = 0;
            m_frozen = 0;
            m_single = rst ? 0 : int'(mode_single);
        end else if (!m_frozen) begin
            if (done) begin
                m_frozen = 1;
                m_pulse = (m_n >= (m_single ? 1 : 2)) ? 1 : 0;
            end else begin
                if (in0_vld) model_add(int'(in0_sad), int'(in0_mvx), int'(in0_mvy));
                if (in1_vld) model_add(int'(in1_sad), int'(in1_mvx), int'(in1_mvy));
            end
        end
    end

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("res_vld", int'(res_vld), m_pulse);
        check("best_sad", int'(best_sad), m_n > 0 ? m_sad[0] : 65535);
        check("best_mvx", int'(best_mvx), m_n > 0 ? m_x[0] : 0);
        check("best_mvy", int'(best_mvy), m_n > 0 ? m_y[0] : 0);
        check("second_sad", int'(second_sad), m_n > 1 ? m_sad[1] : 65535);
        check("second_mvx", int'(second_mvx), m_n > 1 ? m_x[1] : 0);
        check("second_mvy", int'(second_mvy), m_n > 1 ? m_y[1] : 0);
    endtask

    // inputs are set at a falling edge, sampled at the rising edge, checked at the next falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        clr = 0; done = 0; in0_vld = 0; in1_vld = 0;
    endtask

    task automatic drive(input int v0, input int s0, input int x0, input int y0,
                         input int v1, input int s1, input int x1, input int y1);
        in0_vld = v0[0]; in0_sad = 16'(s0); in0_mvx = 4'(x0); in0_mvy = 4'(y0);
        in1_vld = v1[0]; in1_sad = 16'(s1); in1_mvx = 4'(x1); in1_mvy = 4'(y1);
        tick();
    endtask

    task automatic start(input int single);
        clr = 1; mode_single = single[0];
        tick();
    endtask

    task automatic finish_search();
        done = 1;
        tick();
        tick();
    endtask

    task automatic full_search(input int smax);
        for (int k = 0; k < 81; k += 2) begin
            int k1;
            k1 = k + 1;
            drive(1, int'($urandom_range(smax)), k / 9 - 4, k % 9 - 4,
                  k1 < 81 ? 1 : 0, int'($urandom_range(smax)), k1 / 9 - 4, k1 % 9 - 4);
        end
    endtask

    task automatic pool_search(input int cycles);
        for (int c = 0; c < cycles; c++)
            drive(int'($urandom_range(1)), int'($urandom_range(12)),
                  int'($urandom_range(2)) - 1, int'($urandom_range(1)),
                  int'($urandom_range(1)), int'($urandom_range(12)),
                  int'($urandom_range(2)) - 1, int'($urandom_range(1)));
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired in %s", tag);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        tag = "R1";
        @(negedge clk);
        tick(); rst = 1; tick();
        rst = 0;
        tick();

        // R2 / R4: full raster search, two sources per cycle
        for (int r = 0; r < 4; r++) begin
            tag = "R2"; start(0);
            tag = "R4"; full_search(r == 0 ? 60000 : 300);
            tag = "R8"; finish_search();
        end

        // R10: a single candidate appears the next cycle
        tag = "R10"; start(0);
        drive(1, 77, 2, -3, 0, 0, 0, 0);
        check("R10 best_sad next cycle", int'(best_sad), 77);
        check("R10 second stays cleared", int'(second_sad), 65535);

        // R3: ties, source 0 first in the same cycle
        tag = "R3"; start(0);
        drive(1, 5, 1, 1, 1, 5, -1, -1);
        check("R3 source0 keeps best", int'(best_mvx), 1);
        check("R3 source1 second", int'(second_mvx), -1);
        drive(1, 5, 2, 2, 1, 5, 3, 3);
        check("R3 earlier tie not displaced", int'(best_mvx), 1);
        tag = "R3"; full_search(0);
        finish_search();

        // R5: repeats of stored vectors
        tag = "R5"; start(0);
        drive(1, 50, 1, 1, 1, 40, 1, 1);
        check("R5 repeat lowers own sad", int'(best_sad), 40);
        check("R5 no duplicate second", int'(second_sad), 65535);
        drive(1, 60, 2, 2, 0, 0, 0, 0);
        drive(1, 30, 2, 2, 0, 0, 0, 0);
        check("R5 second undercuts best swaps", int'(best_mvx), 2);
        check("R5 old best moves down", int'(second_mvx), 1);
        drive(1, 90, 2, 2, 1, 45, 1, 1);
        check("R5 larger repeat ignored", int'(best_sad), 30);
        for (int r = 0; r < 6; r++) begin
            tag = "R5"; start(0);
            pool_search(30);
            finish_search();
        end

        // R6: single minimum mode
        for (int r = 0; r < 3; r++) begin
            tag = "R6"; start(1);
            if (r == 0) full_search(500); else pool_search(25);
            check("R6 second cleared", int'(second_sad), 65535);
            finish_search();
        end

        // R7: done freezes, including inputs in the done cycle
        tag = "R7"; start(0);
        drive(1, 100, 0, 1, 1, 200, 0, 2);
        in0_vld = 1; in0_sad = 1; in0_mvx = 3; in0_mvy = 3;
        done = 1; tick();
        for (int c = 0; c < 4; c++) drive(1, 0, -2, -2, 1, 0, 1, -1);
        check("R7 best held", int'(best_sad), 100);
        check("R7 second held", int'(second_sad), 200);

        // R8: strobe needs two distinct vectors in pair mode, and fires once
        tag = "R8"; start(0);
        drive(1, 9, 1, 0, 1, 4, 1, 0);
        done = 1; tick();
        check("R8 no strobe with one vector", int'(res_vld), 0);
        done = 1; tick();
        check("R8 second done silent", int'(res_vld), 0);
        start(1);
        done = 1; tick();
        check("R8 empty single no strobe", int'(res_vld), 0);
        start(1);
        drive(1, 3, 0, 0, 0, 0, 0, 0);
        done = 1; tick();
        check("R8 single strobe", int'(res_vld), 1);
        tick();
        check("R8 strobe one cycle", int'(res_vld), 0);

        // R9: clear wins over done and candidates
        tag = "R9"; start(0);
        drive(1, 10, 1, 2, 1, 20, 2, 1);
        clr = 1; done = 1; mode_single = 0;
        in0_vld = 1; in0_sad = 5; in0_mvx = 0; in0_mvy = 0;
        tick();
        check("R9 clear empties", int'(best_sad), 65535);
        check("R9 no strobe", int'(res_vld), 0);
        drive(1, 8, 1, 1, 0, 0, 0, 0);
        check("R9 not frozen after clear", int'(best_sad), 8);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule